// File: doc/BRIEF.md
# Trap and Interrupt Entry Controller

This block decides, once per clock, whether the processor takes a trap, and performs the trap entry on the supervisor state that it owns. That state is the trap-enable bit, the current and previous supervisor bits, the processor interrupt level, the current window pointer, the window-invalid mask and the trap base register. Four sources can request a trap. These are an internal trap already pending in the pipeline, a software trap instruction, a window save or restore that would land on an invalid window, and an external interrupt level. One source wins in a cycle. If traps are enabled, the block rotates the window, updates the status fields, puts the trap type in the base register and presents the vector. It also asks the register file to store the interrupted PC and NPC in local registers 17 and 18 of the new window.

A trap that arrives while traps are disabled is not taken. Instead the block enters a sticky error mode. Window save and restore requests that do not fault move the window pointer directly. A plain state-write port loads the status fields, the mask and the base address.

Top module: `trap_entry_ctrl`

## Requirements
- R1: A synchronous active-low reset sets S=1, ET=0, PS=0, PIL=0, CWP=0, WIM=0, trap base register=0, clears error mode and leaves take_o low.
- R2: An external level is accepted only when it is nonzero, ET=1, no other trap source is requesting, and either the level is 15 or it is strictly greater than PIL.
- R3: An accepted interrupt enters with trap type 16 plus the level.
- R4: At most one entry happens per cycle. The fixed priority is internal trap first, then software trap, then window fault, then interrupt.
- R5: A trap request while ET=0 takes no entry. It sets err_mode_o, which stays set until reset, and leaves CWP unchanged.
- R6: On entry the trap type goes to tbr_o[11:4], tbr_o[31:12] is kept and tbr_o[3:0] is zero. new_pc_o equals the new tbr_o and new_npc_o equals it plus 4.
- R7: On entry ET becomes 0, PS takes the old S, S becomes 1, and CWP becomes the old CWP minus one modulo the window count.
- R8: On entry lcl_we_o pulses for one cycle, lcl_win_o gives the new CWP, and lcl_pc_o and lcl_npc_o carry pc_i and npc_i from the request cycle. The register file stores them in local registers 17 and 18.
- R9: win_op_i=1 (save) decrements CWP and win_op_i=2 (restore) increments it, modulo the window count, when the target window's WIM bit is clear.
- R10: When the target window's WIM bit is set, a save traps with type 0x05 and a restore with type 0x06. The entry then rotates from the unmoved CWP.
- R11: A software trap request has trap type 0x80 OR the low 7 bits of sw_a_i+sw_b_i.
- R12: The state-write port uses st_sel_i 0 for status, 1 for WIM (bits NWIN-1:0) and 2 for the base (bits 31:12). The status word has PIL in 11:8, S in 7, PS in 6, ET in 5 and CWP in the low bits.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| trap_req_i | input | 1 | Internal trap pending |
| trap_tt_i | input | 8 | Type of the internal trap |
| sw_req_i | input | 1 | Software trap instruction |
| sw_a_i | input | XLEN | First software trap operand |
| sw_b_i | input | XLEN | Second software trap operand |
| win_op_i | input | 2 | 0 none, 1 save, 2 restore |
| irq_lvl_i | input | 4 | External interrupt level |
| pc_i | input | XLEN | PC of the instruction in flight |
| npc_i | input | XLEN | NPC of the instruction in flight |
| st_we_i | input | 1 | State write enable |
| st_sel_i | input | 2 | State write target |
| st_data_i | input | XLEN | State write data |
| take_o | output | 1 | Trap entry happened |
| new_pc_o | output | XLEN | Vector PC |
| new_npc_o | output | XLEN | Vector NPC |
| lcl_we_o | output | 1 | Save PC/NPC into the new window |
| lcl_win_o | output | CWP_W | Window that receives the save |
| lcl_pc_o | output | XLEN | Value for local register 17 |
| lcl_npc_o | output | XLEN | Value for local register 18 |
| err_mode_o | output | 1 | Error mode |
| et_o | output | 1 | Traps enabled |
| s_o | output | 1 | Supervisor |
| ps_o | output | 1 | Previous supervisor |
| pil_o | output | 4 | Interrupt level mask |
| cwp_o | output | CWP_W | Current window pointer |
| wim_o | output | NWIN | Window-invalid mask |
| tbr_o | output | XLEN | Trap base register |

## Verification
Every result of this block is registered once. A request, a window operation or a state write driven before a rising edge shows up on the outputs right after that edge, and the outputs then hold until the next event. The bench drives inputs on the falling edge, and it samples on the falling edge that follows the very next rising edge. Each check therefore looks exactly one cycle after its stimulus. Before the next stimulus, the bench reads back the state a suppressed event could have changed, such as CWP after an error-mode trap.

// File: rtl/trap_pkg.sv
// Shared constants and encodings for the trap entry controller.
// Assumes: 8-bit trap types, 4-bit interrupt levels.
package trap_pkg;
    localparam int TT_W  = 8;
    localparam int PIL_W = 4;

    typedef enum logic [1:0] {
        WOP_NONE    = 2'd0,
        WOP_SAVE    = 2'd1,
        WOP_RESTORE = 2'd2,
        WOP_IDLE    = 2'd3
    } win_op_e;

    typedef enum logic [1:0] {
        SEL_STAT = 2'd0,
        SEL_WIM  = 2'd1,
        SEL_TBA  = 2'd2,
        SEL_NONE = 2'd3
    } st_sel_e;

    localparam logic [TT_W-1:0] TT_WOVF     = 8'h05;
    localparam logic [TT_W-1:0] TT_WUNF     = 8'h06;
    localparam logic [TT_W-1:0] TT_IRQ_BASE = 8'h10;
    localparam logic [TT_W-1:0] TT_SW_BASE  = 8'h80;

    // status word bit positions used by the write port
    localparam int STAT_PIL_LO = 8;
    localparam int STAT_S      = 7;
    localparam int STAT_PS     = 6;
    localparam int STAT_ET     = 5;
endpackage

// File: rtl/trap_window_chk.sv
// Window pointer arithmetic and invalid-mask check for save/restore.
// Computes the pointer one below and one above the current one (modulo
// NWIN), picks the target for the requested operation and flags a fault
// when the target's mask bit is set. Purely combinational.
module trap_window_chk
    import trap_pkg::*;
#(
    parameter int NWIN  = 8,
    parameter int CWP_W = $clog2(NWIN)
) (
    input  logic [CWP_W-1:0] cwp_i,
    input  logic [NWIN-1:0]  wim_i,
    input  logic [1:0]       op_i,
    output logic [CWP_W-1:0] dn_o,
    output logic [CWP_W-1:0] tgt_o,
    output logic             move_o,
    output logic             fault_o,
    output logic [TT_W-1:0]  fault_tt_o
);
    localparam logic [CWP_W-1:0] LAST = CWP_W'(NWIN - 1);

    logic [CWP_W-1:0] up;
    win_op_e          op;

    assign op = win_op_e'(op_i);

    // wraparound: free for a power-of-two count, compare otherwise
    generate
        if ((1 << CWP_W) == NWIN) begin : g_pow2
            assign dn_o = cwp_i - 1'b1;
            assign up   = cwp_i + 1'b1;
        end else begin : g_cmp
            assign dn_o = (cwp_i == '0)   ? LAST : cwp_i - 1'b1;
            assign up   = (cwp_i == LAST) ? '0   : cwp_i + 1'b1;
        end
    endgenerate

    // select target and test its mask bit
    always_comb begin
        tgt_o      = cwp_i;
        move_o     = 1'b0;
        fault_o    = 1'b0;
        fault_tt_o = TT_WOVF;
        if (op == WOP_SAVE) begin
            tgt_o      = dn_o;
            fault_o    = wim_i[dn_o];
            move_o     = !wim_i[dn_o];
            fault_tt_o = TT_WOVF;
        end else if (op == WOP_RESTORE) begin
            tgt_o      = up;
            fault_o    = wim_i[up];
            move_o     = !wim_i[up];
            fault_tt_o = TT_WUNF;
        end
    end

    // R9
    always_comb begin
        win_move_fault_excl_chk: assert (!(move_o && fault_o));
    end
endmodule

// File: rtl/trap_irq_filter.sv
// Interrupt acceptance: level nonzero, traps enabled, nothing else
// requesting, and level 15 or above the mask. Combinational.
module trap_irq_filter
    import trap_pkg::*;
(
    input  logic [PIL_W-1:0] lvl_i,
    input  logic [PIL_W-1:0] pil_i,
    input  logic             et_i,
    input  logic             busy_i,
    output logic             accept_o,
    output logic [TT_W-1:0]  tt_o
);
    logic above;

    // level 15 passes any mask
    always_comb begin
        above    = (lvl_i == '1) || (lvl_i > pil_i);
        accept_o = (lvl_i != '0) && et_i && !busy_i && above;
        tt_o     = TT_IRQ_BASE + TT_W'(lvl_i);
    end

    // R2
    always_comb begin
        irq_gate_chk: assert (!(accept_o === 1'b1) || (et_i && lvl_i != '0));
    end
endmodule

// File: rtl/trap_prio_sel.sv
// Picks one trap source per cycle: internal, software, window fault,
// interrupt, in that order, and forms the software trap type.
module trap_prio_sel
    import trap_pkg::*;
#(
    parameter int XLEN = 32
) (
    input  logic            int_req_i,
    input  logic [TT_W-1:0] int_tt_i,
    input  logic            sw_req_i,
    input  logic [XLEN-1:0] sw_a_i,
    input  logic [XLEN-1:0] sw_b_i,
    input  logic            win_fault_i,
    input  logic [TT_W-1:0] win_tt_i,
    input  logic            irq_acc_i,
    input  logic [TT_W-1:0] irq_tt_i,
    output logic            any_o,
    output logic [TT_W-1:0] tt_o
);
    logic [6:0] sw_sum;
    logic       unused_sw;

    assign sw_sum    = sw_a_i[6:0] + sw_b_i[6:0];
    assign unused_sw = ^{sw_a_i, sw_b_i};

    // fixed-priority selection
    always_comb begin
        any_o = 1'b1;
        tt_o  = '0;
        if (int_req_i)        tt_o = int_tt_i;
        else if (sw_req_i)    tt_o = TT_SW_BASE | TT_W'(sw_sum);
        else if (win_fault_i) tt_o = win_tt_i;
        else if (irq_acc_i)   tt_o = irq_tt_i;
        else                  any_o = 1'b0;
    end

    // R11
    always_comb begin
        sw_tt_msb_chk: assert (!(sw_req_i === 1'b1 && int_req_i === 1'b0) || tt_o[7]);
    end
endmodule

// File: rtl/trap_entry_ctrl.sv
// Trap and interrupt entry controller.
// Owns ET, S, PS, PIL, CWP, the window-invalid mask and the trap base
// register. Each cycle at most one trap is selected; with ET set it is
// entered (window rotate, status update, vector out, PC/NPC save request),
// with ET clear the sticky error mode is set instead. Assumes the register
// file writes lcl_pc_o/lcl_npc_o to locals 17/18 of lcl_win_o when lcl_we_o.
module trap_entry_ctrl
    import trap_pkg::*;
#(
    parameter int NWIN  = 8,
    parameter int XLEN  = 32,
    parameter int CWP_W = $clog2(NWIN)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             trap_req_i,
    input  logic [7:0]       trap_tt_i,
    input  logic             sw_req_i,
    input  logic [XLEN-1:0]  sw_a_i,
    input  logic [XLEN-1:0]  sw_b_i,
    input  logic [1:0]       win_op_i,
    input  logic [3:0]       irq_lvl_i,
    input  logic [XLEN-1:0]  pc_i,
    input  logic [XLEN-1:0]  npc_i,
    input  logic             st_we_i,
    input  logic [1:0]       st_sel_i,
    input  logic [XLEN-1:0]  st_data_i,
    output logic             take_o,
    output logic [XLEN-1:0]  new_pc_o,
    output logic [XLEN-1:0]  new_npc_o,
    output logic             lcl_we_o,
    output logic [CWP_W-1:0] lcl_win_o,
    output logic [XLEN-1:0]  lcl_pc_o,
    output logic [XLEN-1:0]  lcl_npc_o,
    output logic             err_mode_o,
    output logic             et_o,
    output logic             s_o,
    output logic             ps_o,
    output logic [3:0]       pil_o,
    output logic [CWP_W-1:0] cwp_o,
    output logic [NWIN-1:0]  wim_o,
    output logic [XLEN-1:0]  tbr_o
);
    localparam int TBA_W = XLEN - 12;

    logic             et_q, s_q, ps_q, err_q, take_q;
    logic [3:0]       pil_q;
    logic [CWP_W-1:0] cwp_q, lwin_q;
    logic [NWIN-1:0]  wim_q;
    logic [TBA_W-1:0] tba_q;
    logic [TT_W-1:0]  tt_q;
    logic [XLEN-1:0]  lpc_q, lnpc_q;

    logic [CWP_W-1:0] cwp_dn, win_tgt;
    logic             win_move, win_fault, irq_acc, trap_any;
    logic [TT_W-1:0]  win_tt, irq_tt, sel_tt;
    logic             unused_st;
    st_sel_e          st_sel;

    assign st_sel    = st_sel_e'(st_sel_i);
    assign unused_st = ^st_data_i;

    trap_window_chk #(.NWIN(NWIN), .CWP_W(CWP_W)) u_win (
        .cwp_i      (cwp_q),
        .wim_i      (wim_q),
        .op_i       (win_op_i),
        .dn_o       (cwp_dn),
        .tgt_o      (win_tgt),
        .move_o     (win_move),
        .fault_o    (win_fault),
        .fault_tt_o (win_tt)
    );

    trap_irq_filter u_irq (
        .lvl_i    (irq_lvl_i),
        .pil_i    (pil_q),
        .et_i     (et_q),
        .busy_i   (trap_req_i || sw_req_i || win_fault),
        .accept_o (irq_acc),
        .tt_o     (irq_tt)
    );

    trap_prio_sel #(.XLEN(XLEN)) u_sel (
        .int_req_i   (trap_req_i),
        .int_tt_i    (trap_tt_i),
        .sw_req_i    (sw_req_i),
        .sw_a_i      (sw_a_i),
        .sw_b_i      (sw_b_i),
        .win_fault_i (win_fault),
        .win_tt_i    (win_tt),
        .irq_acc_i   (irq_acc),
        .irq_tt_i    (irq_tt),
        .any_o       (trap_any),
        .tt_o        (sel_tt)
    );

    // supervisor state: trap entry, else state write, else window move
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            et_q   <= 1'b0;
            s_q    <= 1'b1;
            ps_q   <= 1'b0;
            pil_q  <= '0;
            cwp_q  <= '0;
            wim_q  <= '0;
            tba_q  <= '0;
            tt_q   <= '0;
            err_q  <= 1'b0;
            take_q <= 1'b0;
        end else begin
            take_q <= 1'b0;
            if (trap_any) begin
                if (et_q) begin
                    take_q <= 1'b1;
                    et_q   <= 1'b0;
                    ps_q   <= s_q;
                    s_q    <= 1'b1;
                    cwp_q  <= cwp_dn;
                    tt_q   <= sel_tt;
                end else begin
                    err_q  <= 1'b1;
                end
            end else if (st_we_i) begin
                case (st_sel)
                    SEL_STAT: begin
                        pil_q <= st_data_i[STAT_PIL_LO +: 4];
                        s_q   <= st_data_i[STAT_S];
                        ps_q  <= st_data_i[STAT_PS];
                        et_q  <= st_data_i[STAT_ET];
                        cwp_q <= st_data_i[CWP_W-1:0];
                    end
                    SEL_WIM:  wim_q <= st_data_i[NWIN-1:0];
                    SEL_TBA:  tba_q <= st_data_i[XLEN-1:12];
                    default:  ;
                endcase
            end else if (win_move) begin
                cwp_q <= win_tgt;
            end
        end
    end

    // save request payload captured with the entry
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            lwin_q <= '0;
            lpc_q  <= '0;
            lnpc_q <= '0;
        end else if (trap_any && et_q) begin
            lwin_q <= cwp_dn;
            lpc_q  <= pc_i;
            lnpc_q <= npc_i;
        end
    end

    assign tbr_o      = {tba_q, tt_q, 4'h0};
    assign new_pc_o   = tbr_o;
    assign new_npc_o  = tbr_o + XLEN'(4);
    assign take_o     = take_q;
    assign lcl_we_o   = take_q;
    assign lcl_win_o  = lwin_q;
    assign lcl_pc_o   = lpc_q;
    assign lcl_npc_o  = lnpc_q;
    assign err_mode_o = err_q;
    assign et_o       = et_q;
    assign s_o        = s_q;
    assign ps_o       = ps_q;
    assign pil_o      = pil_q;
    assign cwp_o      = cwp_q;
    assign wim_o      = wim_q;

    // R7
    entry_psr_chk: assert property (@(posedge clk) disable iff (!rst_n)
        take_o |-> (!et_o && s_o));

    // R7
    entry_ps_copy_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (trap_any && et_q) |=> (ps_o == $past(s_q)));

    // R7
    entry_cwp_rot_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (trap_any && et_q) |=> (cwp_o == (($past(cwp_q) == '0) ?
            CWP_W'(NWIN - 1) : $past(cwp_q) - 1'b1)));

    // R5
    err_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        err_mode_o |=> err_mode_o);

    // R5
    err_no_entry_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (trap_any && !et_q) |=> (!take_o && $stable(cwp_o)));

    // R6
    vector_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        take_o |-> (new_npc_o == new_pc_o + XLEN'(4)));

    // R8
    save_win_chk: assert property (@(posedge clk) disable iff (!rst_n)
        lcl_we_o |-> (lcl_win_o == cwp_o));
endmodule

// File: tb/trap_entry_ctrl_tb_top.sv
module trap_entry_ctrl_tb_top;
    localparam int NWIN = 8;
    localparam int XLEN = 32;
    localparam int CW   = 3;

    logic clk = 1'b0;
    logic rst_n;
    logic trap_req, sw_req, st_we;
    logic [7:0] trap_tt;
    logic [XLEN-1:0] sw_a, sw_b, pc, npc, st_data;
    logic [1:0] win_op, st_sel;
    logic [3:0] irq;
    logic take, lwe, err, et, s, ps;
    logic [XLEN-1:0] npc_o, nnpc_o, lpc, lnpc, tbr;
    logic [CW-1:0] lwin, cwp;
    logic [3:0] pil;
    logic [NWIN-1:0] wim;

    int total = 0;
    int bad   = 0;
    bit done  = 0;

    always #2 clk = ~clk;

    trap_entry_ctrl #(.NWIN(NWIN), .XLEN(XLEN)) dut_i (
        .clk(clk), .rst_n(rst_n), .trap_req_i(trap_req), .trap_tt_i(trap_tt),
        .sw_req_i(sw_req), .sw_a_i(sw_a), .sw_b_i(sw_b), .win_op_i(win_op),
        .irq_lvl_i(irq), .pc_i(pc), .npc_i(npc), .st_we_i(st_we),
        .st_sel_i(st_sel), .st_data_i(st_data), .take_o(take),
        .new_pc_o(npc_o), .new_npc_o(nnpc_o), .lcl_we_o(lwe), .lcl_win_o(lwin),
        .lcl_pc_o(lpc), .lcl_npc_o(lnpc), .err_mode_o(err), .et_o(et),
        .s_o(s), .ps_o(ps), .pil_o(pil), .cwp_o(cwp), .wim_o(wim), .tbr_o(tbr)
    );

    task automatic chk(input bit ok, input string req, input logic [31:0] act,
                       input logic [31:0] exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic step();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic wr(input logic [1:0] sel, input logic [31:0] d);
        st_we = 1'b1; st_sel = sel; st_data = d;
        step();
        st_we = 1'b0;
    endtask

    function automatic logic [31:0] stat(input logic [3:0] p, input bit sv,
                                         input bit psv, input bit e,
                                         input logic [2:0] w);
        return {20'h0, p, sv, psv, e, 2'b00, w};
    endfunction

    // full entry check: vector, status fields, save request
    task automatic exp_entry(input string req, input logic [7:0] tt,
                             input logic [19:0] base, input logic [2:0] oldw,
                             input bit olds, input logic [31:0] p,
                             input logic [31:0] np);
        logic [31:0] v;
        v = {base, tt, 4'h0};
        chk(take === 1'b1, req, {31'h0, take}, 32'h1);
        chk(tbr === v, {req, " R6 tbr"}, tbr, v);
        chk(npc_o === v && nnpc_o === v + 32'd4, {req, " R6 vector"}, nnpc_o, v + 32'd4);
        chk(et === 1'b0 && s === 1'b1 && ps === olds, {req, " R7 psr"},
            {29'h0, et, s, ps}, {29'h0, 1'b0, 1'b1, olds});
        chk(cwp === oldw - 3'd1, {req, " R7 cwp"}, {29'h0, cwp}, {29'h0, oldw - 3'd1});
        chk(lwe === 1'b1 && lwin === oldw - 3'd1 && lpc === p && lnpc === np,
            {req, " R8 save"}, lpc, p);
    endtask

    initial begin
        #400000;
        if (!done) begin
            total++; bad++;
            $display("FAIL watchdog expired");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        rst_n = 1'b0; trap_req = 0; trap_tt = 0; sw_req = 0; sw_a = 0; sw_b = 0;
        win_op = 0; irq = 0; pc = 0; npc = 0; st_we = 0; st_sel = 0; st_data = 0;
        step(); step();
        rst_n = 1'b1;
        step();
        // R1 reset state
        chk(s === 1 && et === 0 && ps === 0 && pil === 0 && cwp === 0 && wim === 0
            && tbr === 0 && err === 0 && take === 0, "R1 reset", tbr, 32'h0);

        // R12 write port layout
        wr(2'd0, stat(4'h9, 1'b0, 1'b1, 1'b1, 3'd5));
        chk(pil === 4'h9 && s === 0 && ps === 1 && et === 1 && cwp === 5, "R12 status",
            {pil, s, ps, et, cwp}, {4'h9, 1'b0, 1'b1, 1'b1, 3'd5});
        wr(2'd1, 32'h0000_00A5);
        chk(wim === 8'hA5, "R12 wim", {24'h0, wim}, 32'hA5);
        wr(2'd2, 32'h1234_5FFF);
        chk(tbr[31:12] === 20'h12345, "R12 tba", tbr, 32'h12345000);
        wr(2'd1, 32'h0);

        // R2 R3 interrupt sweep over every mask and level
        for (int p = 0; p < 16; p++) begin
            for (int l = 0; l < 16; l++) begin
                bit acc;
                wr(2'd0, stat(p[3:0], 1'b1, 1'b0, 1'b1, 3'd3));
                wr(2'd2, 32'hABCDE000);
                pc = 32'h1000 + 32'(p * 64 + l * 4); npc = pc + 32'd4;
                irq = l[3:0];
                step();
                irq = 4'h0;
                acc = (l != 0) && (l == 15 || l > p);
                if (acc)
                    exp_entry("R3 irq", 8'(16 + l), 20'hABCDE, 3'd3, 1'b1, pc, npc);
                else
                    chk(take === 1'b0 && cwp === 3'd3 && et === 1'b1, "R2 irq masked",
                        {31'h0, take}, 32'h0);
            end
        end

        // R2 interrupt ignored with ET=0, and no error mode
        wr(2'd0, stat(4'h0, 1'b1, 1'b0, 1'b0, 3'd2));
        irq = 4'hF; step(); irq = 4'h0;
        chk(take === 0 && err === 0 && cwp === 3'd2, "R2 et off", {31'h0, take}, 32'h0);

        // R4 internal trap beats all other sources
        wr(2'd0, stat(4'h0, 1'b0, 1'b0, 1'b1, 3'd0));
        wr(2'd1, 32'h0000_0080);
        pc = 32'h4000; npc = 32'h4004;
        trap_req = 1; trap_tt = 8'h2A; sw_req = 1; sw_a = 32'h7; win_op = 2'd1; irq = 4'hF;
        step();
        trap_req = 0; sw_req = 0; win_op = 0; irq = 0;
        exp_entry("R4 prio int", 8'h2A, 20'hABCDE, 3'd0, 1'b0, 32'h4000, 32'h4004);

        // R4 software beats window fault and interrupt
        wr(2'd0, stat(4'h0, 1'b1, 1'b0, 1'b1, 3'd0));
        sw_req = 1; sw_a = 32'h3; sw_b = 32'h4; win_op = 2'd1; irq = 4'hF;
        step();
        sw_req = 0; win_op = 0; irq = 0;
        exp_entry("R4 prio sw", 8'h87, 20'hABCDE, 3'd0, 1'b1, 32'h4000, 32'h4004);

        // R4 window fault beats interrupt
        wr(2'd0, stat(4'h0, 1'b1, 1'b0, 1'b1, 3'd0));
        win_op = 2'd1; irq = 4'hF;
        step();
        win_op = 0; irq = 0;
        exp_entry("R4 prio win", 8'h05, 20'hABCDE, 3'd0, 1'b1, 32'h4000, 32'h4004);
        step();
        chk(take === 1'b0, "R4 single pulse", {31'h0, take}, 32'h0);

        // R11 software trap type sweep
        for (int k = 0; k < 12; k++) begin
            logic [31:0] a, b;
            logic [7:0] e;
            a = 32'h1234_5678 * 32'(k + 1); b = 32'hFFFF_FFF0 + 32'(k * 7);
            e = 8'h80 | {1'b0, 7'(a + b)};
            wr(2'd0, stat(4'h0, 1'b1, 1'b0, 1'b1, 3'd6));
            sw_req = 1; sw_a = a; sw_b = b; step(); sw_req = 0;
            chk(take === 1 && tbr[11:4] === e, "R11 sw tt", {24'h0, tbr[11:4]}, {24'h0, e});
        end

        // R9 R10 window save/restore against every single-bit mask
        for (int w = 0; w < 8; w++) begin
            for (int bpos = 0; bpos < 8; bpos++) begin
                for (int op = 1; op < 3; op++) begin
                    logic [2:0] tgt;
                    tgt = (op == 1) ? 3'(w - 1) : 3'(w + 1);
                    wr(2'd1, 32'(1 << bpos));
                    wr(2'd0, stat(4'hF, 1'b1, 1'b0, 1'b1, w[2:0]));
                    win_op = op[1:0]; step(); win_op = 0;
                    if (tgt == 3'(bpos))
                        chk(take === 1 && cwp === 3'(w - 1) &&
                            tbr[11:4] === ((op == 1) ? 8'h05 : 8'h06), "R10 win fault",
                            {24'h0, tbr[11:4]}, {24'h0, (op == 1) ? 8'h05 : 8'h06});
                    else
                        chk(take === 0 && cwp === tgt, "R9 win move",
                            {29'h0, cwp}, {29'h0, tgt});
                end
            end
        end

        // R5 trap with ET=0 enters sticky error mode, state untouched
        wr(2'd0, stat(4'h0, 1'b1, 1'b0, 1'b0, 3'd4));
        trap_req = 1; trap_tt = 8'h11; step(); trap_req = 0;
        chk(err === 1 && take === 0 && cwp === 3'd4 && lwe === 0, "R5 error entry",
            {31'h0, err}, 32'h1);
        step();
        chk(err === 1 && cwp === 3'd4, "R5 error sticky", {31'h0, err}, 32'h1);

        // R1 reset clears error mode
        rst_n = 0; step(); rst_n = 1; step();
        chk(err === 0 && s === 1 && et === 0 && cwp === 0, "R1 reset after error",
            {31'h0, err}, 32'h0);

        done = 1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule